// File: doc/BRIEF.md
# Forwarded Clock Skew Unit

This block sets the launch timing of a write toward a bank of synchronous SRAMs. A write is announced by an address strobe on a core-cycle boundary. The block re-issues that strobe as the index launch. It then issues the write word a programmable number of whole core cycles later. It also drives a forwarded clock whose edge trails the write word by a programmable number of half-cycle phases. The board can then meet setup time at heavily loaded index pins, while the lightly loaded data and clock pins stay close together.

The block runs on a phase clock `clk` that ticks twice per core cycle. `core_en` is high on every other tick and marks the ticks that end a core cycle. Two 2-bit configuration words pick the delays. They are latched only on core-cycle boundaries. The forwarded clock runs freely with a period of one core cycle and is not gated per write. The one exception is the phase encoding 0, which holds the clock low. The inbound strobe is valid-only. There is no ready signal and no back-pressure, because the SRAM port cannot stall. A strobe offered on a tick that is not a core boundary is dropped. The outbound write strobe is equally unconditional.

Top module: `fwdclk_skew`

## Requirements
- R1: While `rst_n` is low, `idx_stb_o`, `wd_vld_o`, `wd_data_o` and `fclk_o` are all 0. The latched phase encoding resets to 0, so `fclk_o` stays low on the first tick after reset is released.
- R2: `cyc_dly_cfg` and `ph_dly_cfg` are captured only at edges where `core_en` is 1. A value held only across a non-boundary edge has no effect on later strobes or on `fclk_o`.
- R3: `addr_vld` seen at an edge where `core_en` is 1 makes `idx_stb_o` high for exactly the two ticks after that edge. In this document, "tick k" counts from the first of those two ticks, which is tick 0.
- R4: With cycle encoding N (0 to 3, equal to the whole core cycles of delay), `wd_vld_o` is first high at tick 2N and stays high for exactly two ticks. `wd_data_o` shows the captured `wdata` from tick 2N until the next word is issued.
- R5: With phase encoding 0, `fclk_o` stays low.
- R6: With phase encoding 1, 2 or 3, `fclk_o` runs freely whether or not writes occur. It is high for one tick and then low for one tick.
- R7: With phase encoding E in 1 to 3, `fclk_o` is high at tick 2N+E-1 and low at the tick before it, so E selects E-1 half-cycle phases after the write word. The largest skew from index launch to clock edge is 8 phases.
- R8: `addr_vld` at an edge where `core_en` is 0 is ignored. Neither `idx_stb_o` nor `wd_vld_o` rises because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, two ticks per core cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| core_en | input | 1 | High on the tick that ends a core cycle |
| addr_vld | input | 1 | Write address strobe, sampled on core ticks |
| wdata | input | DATA_W | Write word offered with the strobe |
| cyc_dly_cfg | input | 2 | Whole-cycle delay from index to data |
| ph_dly_cfg | input | 2 | Phase delay from data to clock; 0 turns the clock off |
| idx_stb_o | output | 1 | Index launch strobe |
| wd_vld_o | output | 1 | Delayed write-data strobe |
| wd_data_o | output | DATA_W | Delayed write word |
| fclk_o | output | 1 | Forwarded SRAM clock |

## Verification
A stuck or mis-wired stage in the cycle pipeline moves the data strobe by a multiple of two ticks. It shows within eight ticks of the index launch. A wrong phase tap puts `fclk_o` high on ticks of the wrong parity relative to the data strobe. This is visible within one core cycle. Taps two phases apart share a parity and look the same at a one-cycle clock period. A configuration latch that samples off-boundary shows as a clock or a data strobe appearing where the captured settings forbid one, at the very next write.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int unsigned CYC_W = 2;
  localparam int unsigned PH_W  = 2;

  typedef enum logic [PH_W-1:0] {
    PH_OFF = 2'd0,
    PH_D0  = 2'd1,
    PH_D1  = 2'd2,
    PH_D2  = 2'd3
  } ph_enc_e;
endpackage

// File: rtl/fcd_cfg_latch.sv
module fcd_cfg_latch
  import fcd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            core_en,
  input  logic [CYC_W-1:0] cyc_in,
  input  logic [PH_W-1:0]  ph_in,
  output logic [CYC_W-1:0] cyc_q,
  output logic [PH_W-1:0]  ph_q
);
  // settings move only on a core boundary
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q <= '0;
      ph_q  <= PH_OFF;
    end else if (core_en) begin
      cyc_q <= cyc_in;
      ph_q  <= ph_in;
    end
  end
endmodule

// File: rtl/fcd_cycle_pipe.sv
module fcd_cycle_pipe
  import fcd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_en,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CYC_W-1:0]  sel,
  output logic              head_vld,
  output logic              tap_vld,
  output logic [DATA_W-1:0] out_data
);
  localparam int unsigned DEPTH = 1 << CYC_W;

  logic [DEPTH-1:0]  stg_v;
  logic [DATA_W-1:0] stg_d [DEPTH];
  logic [DEPTH-1:0]  nxt_v;
  logic [DATA_W-1:0] nxt_d [DEPTH];
  logic [DATA_W-1:0] hold_q;

  // value each stage takes at the next core edge
  for (genvar k = 0; k < DEPTH; k++) begin : g_nxt
    if (k == 0) begin : g_head
      assign nxt_v[k] = in_vld;
      assign nxt_d[k] = in_data;
    end else begin : g_body
      assign nxt_v[k] = stg_v[k-1];
      assign nxt_d[k] = stg_d[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_v  <= '0;
      hold_q <= '0;
      for (int k = 0; k < DEPTH; k++) stg_d[k] <= '0;
    end else if (core_en) begin
      stg_v <= nxt_v;
      for (int k = 0; k < DEPTH; k++) stg_d[k] <= nxt_d[k];
      if (nxt_v[sel]) hold_q <= nxt_d[sel];
    end
  end

  assign head_vld = stg_v[0];
  assign tap_vld  = stg_v[sel];
  assign out_data = hold_q;
endmodule

// File: rtl/fcd_phase_pipe.sv
module fcd_phase_pipe
  import fcd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            core_en,
  input  logic [PH_W-1:0] sel,
  output logic            fclk
);
  localparam int unsigned TAPS = (1 << PH_W) - 1;

  logic [TAPS-2:0] dly_q;
  logic [TAPS-1:0] tap;
  logic [PH_W-1:0] idx;
  logic            pick;
  logic            fclk_q;

  // tap 0 is the boundary marker itself; later taps trail by one phase each
  assign tap  = {dly_q, core_en};
  assign idx  = sel - 1'b1;
  assign pick = (sel != PH_OFF) && tap[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dly_q  <= '0;
      fclk_q <= 1'b0;
    end else begin
      if (TAPS > 2) dly_q <= {dly_q[TAPS-3:0], core_en};
      else          dly_q <= core_en;
      // never high two ticks running, even across a tap switch
      fclk_q <= pick & ~fclk_q;
    end
  end

  assign fclk = fclk_q;
endmodule

// File: rtl/fwdclk_skew.sv
module fwdclk_skew
  import fcd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_en,
  input  logic              addr_vld,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CYC_W-1:0]  cyc_dly_cfg,
  input  logic [PH_W-1:0]   ph_dly_cfg,
  output logic              idx_stb_o,
  output logic              wd_vld_o,
  output logic [DATA_W-1:0] wd_data_o,
  output logic              fclk_o
);
  logic [CYC_W-1:0] cyc_q;
  logic [PH_W-1:0]  ph_q;

  fcd_cfg_latch u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .core_en (core_en),
    .cyc_in  (cyc_dly_cfg),
    .ph_in   (ph_dly_cfg),
    .cyc_q   (cyc_q),
    .ph_q    (ph_q)
  );

  fcd_cycle_pipe #(.DATA_W(DATA_W)) u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .core_en  (core_en),
    .in_vld   (addr_vld),
    .in_data  (wdata),
    .sel      (cyc_q),
    .head_vld (idx_stb_o),
    .tap_vld  (wd_vld_o),
    .out_data (wd_data_o)
  );

  fcd_phase_pipe u_ph (
    .clk     (clk),
    .rst_n   (rst_n),
    .core_en (core_en),
    .sel     (ph_q),
    .fclk    (fclk_o)
  );
endmodule

// File: rtl/fwdclk_skew_chk.sv
module fwdclk_skew_chk
  import fcd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_en,
  input logic [PH_W-1:0]   ph_dly_cfg,
  input logic              idx_stb_o,
  input logic              wd_vld_o,
  input logic [DATA_W-1:0] wd_data_o,
  input logic              fclk_o
);
  logic [PH_W-1:0] ph_seen;
  logic [PH_W-1:0] ph_seen_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_seen   <= '0;
      ph_seen_d <= '0;
    end else begin
      if (core_en) ph_seen <= ph_dly_cfg;
      ph_seen_d <= ph_seen;
    end
  end

  AST_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_seen == '0 && ph_seen_d == '0) |-> !fclk_o) else $error("clock while off"); // R5
  AST_ONE_TICK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    fclk_o |=> !fclk_o) else $error("wide clock pulse"); // R6
  AST_IDX_TWO_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idx_stb_o) |=> idx_stb_o) else $error("short index strobe"); // R3
  AST_WD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_vld_o) |=> (wd_vld_o && $stable(wd_data_o))) else $error("short data strobe"); // R4
  AST_IDX_ON_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(core_en) |-> $stable(idx_stb_o)) else $error("index moved off boundary"); // R8
  AST_WD_ON_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(core_en) |-> $stable(wd_vld_o)) else $error("data moved off boundary"); // R4
endmodule

bind fwdclk_skew fwdclk_skew_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/fwdclk_skew_tb.sv
module fwdclk_skew_tb;
  import fcd_pkg::*;

  localparam int unsigned DW = 32;
  localparam int HW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n, core_en, addr_vld;
  logic [DW-1:0]     wdata;
  logic [CYC_W-1:0]  cyc_cfg;
  logic [PH_W-1:0]   ph_cfg;
  logic              idx_stb_o, wd_vld_o, fclk_o;
  logic [DW-1:0]     wd_data_o;

  int n_chk = 0;
  int n_fail = 0;
  logic          h_idx [HW];
  logic          h_wd  [HW];
  logic          h_clk [HW];
  logic [DW-1:0] h_dat [HW];

  fwdclk_skew #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .core_en(core_en), .addr_vld(addr_vld),
    .wdata(wdata), .cyc_dly_cfg(cyc_cfg), .ph_dly_cfg(ph_cfg),
    .idx_stb_o(idx_stb_o), .wd_vld_o(wd_vld_o), .wd_data_o(wd_data_o),
    .fclk_o(fclk_o)
  );

  function automatic int exp_wd_k(input int n);
    return 2 * n;
  endfunction

  function automatic int exp_clk_k(input int n, input int e);
    return 2 * n + e - 1;
  endfunction

  function automatic int first_set(input logic v [HW]);
    for (int k = 0; k < HW; k++) if (v[k] === 1'b1) return k;
    return -1;
  endfunction

  function automatic int count_set(input logic v [HW]);
    int c = 0;
    for (int k = 0; k < HW; k++) if (v[k] === 1'b1) c++;
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // one phase tick; inputs change and outputs are read 1 ns after the edge
  task automatic tick();
    @(posedge clk);
    #1;
    core_en = ~core_en;
  endtask

  task automatic capture();
    for (int k = 0; k < HW; k++) begin
      h_idx[k] = idx_stb_o;
      h_wd[k]  = wd_vld_o;
      h_clk[k] = fclk_o;
      h_dat[k] = wd_data_o;
      tick();
    end
  endtask

  task automatic wait_core();
    while (core_en !== 1'b1) tick();
  endtask

  task automatic run_xfer(input int n, input int e, input logic [DW-1:0] d);
    int fi, fw, ew, c;
    cyc_cfg = CYC_W'(n);
    ph_cfg  = PH_W'(e);
    addr_vld = 1'b0;
    repeat (6) tick();
    wait_core();
    addr_vld = 1'b1;
    wdata = d;
    tick();
    addr_vld = 1'b0;
    capture();
    fi = first_set(h_idx);
    check(fi == 0 && h_idx[1] === 1'b1 && h_idx[2] === 1'b0, "R3 index strobe", fi, 0);
    fw = first_set(h_wd);
    ew = exp_wd_k(n);
    check(fw == ew, "R4 data strobe tick", fw, ew);
    check(h_wd[ew+1] === 1'b1 && h_wd[ew+2] === 1'b0, "R4 data strobe width",
          count_set(h_wd), 2);
    check(h_dat[ew] === d, "R4 data word", h_dat[ew], d);
    if (e == 0) begin
      check(count_set(h_clk) == 0, "R5 clock off", count_set(h_clk), 0);
    end else begin
      c = exp_clk_k(n, e);
      check(h_clk[c] === 1'b1, "R7 clock edge tick", h_clk[c], 1);
      if (c > 0) check(h_clk[c-1] === 1'b0, "R7 low before edge", h_clk[c-1], 0);
      check(h_clk[c+1] === 1'b0 && h_clk[c+2] === 1'b1, "R6 clock period",
            {h_clk[c+1], h_clk[c+2]}, 1);
      check(h_dat[c] === d, "R4 word held at capture edge", h_dat[c], d);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R3 watchdog act=%0d exp=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed;
    int cnt;
    bit alt;
    seed = $urandom(32'd2718);
    rst_n = 1'b0; core_en = 1'b0; addr_vld = 1'b0; wdata = '0;
    cyc_cfg = 2'd2; ph_cfg = 2'd1;
    repeat (4) tick();
    // R1: reset state at the ports
    check(idx_stb_o === 1'b0 && wd_vld_o === 1'b0 && fclk_o === 1'b0,
          "R1 reset outputs", {idx_stb_o, wd_vld_o, fclk_o}, 0);
    check(wd_data_o === '0, "R1 reset data", wd_data_o, 0);
    rst_n = 1'b1;
    tick();
    check(fclk_o === 1'b0, "R1 clock off after release", fclk_o, 0);

    // all sixteen settings, directed
    for (int n = 0; n < 4; n++)
      for (int e = 0; e < 4; e++)
        run_xfer(n, e, DW'(32'hA500_0000 + n * 16 + e));

    // R2: settings shown only across a non-boundary edge are not taken
    cyc_cfg = 2'd0; ph_cfg = 2'd0;
    repeat (6) tick();
    while (core_en !== 1'b0) tick();
    cyc_cfg = 2'd3; ph_cfg = 2'd1;
    tick();
    cyc_cfg = 2'd0; ph_cfg = 2'd0;
    addr_vld = 1'b1; wdata = 32'h0BAD_F00D;
    tick();
    addr_vld = 1'b0;
    capture();
    check(first_set(h_wd) == 0, "R2 cycle setting not taken", first_set(h_wd), 0);
    check(count_set(h_clk) == 0, "R2 phase setting not taken", count_set(h_clk), 0);

    // R8: strobe on a non-boundary edge is dropped
    cyc_cfg = 2'd1; ph_cfg = 2'd1;
    repeat (6) tick();
    while (core_en !== 1'b0) tick();
    addr_vld = 1'b1; wdata = 32'hDEAD_0001;
    tick();
    addr_vld = 1'b0;
    capture();
    check(count_set(h_idx) == 0, "R8 index ignored", count_set(h_idx), 0);
    check(count_set(h_wd) == 0, "R8 data ignored", count_set(h_wd), 0);

    // R6: free-running with no traffic
    capture();
    cnt = count_set(h_clk);
    alt = 1'b1;
    for (int k = 0; k + 1 < HW; k++) if (h_clk[k] === h_clk[k+1]) alt = 1'b0;
    check(cnt == HW / 2 && alt, "R6 free-running clock", cnt, HW / 2);

    // constrained random settings and words
    for (int i = 0; i < 40; i++)
      run_xfer(int'($urandom % 4), int'($urandom % 4), DW'($urandom));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule